// File: doc/BRIEF.md
# Register Extend-and-Shift Unit

This block prepares the second operand of an add or subtract stage. It takes a 64-bit register value, a 3-bit extend-option code and a small left-shift amount. From these it forms one result. A byte, halfword, word or doubleword slice is taken from the low end of the source, zero- or sign-extended, and moved left by the shift amount. The extension and the shift are one fused operation. The sign bit of the slice therefore lands at result bit (slice length + shift - 1), and every bit above it copies that bit. If the shift would push the top of the slice past the result width, the slice is first shortened to the result width minus the shift.

A `in_narrow` input selects a 32-bit result instead of a 64-bit one. In that mode only the low 32 source bits take part, and the upper half of the output reads zero. Shift amounts above 4 are illegal: they raise an error flag and give an all-zero result. Inputs are taken on a clock edge where `in_valid` is high. The registered result comes out with `out_valid` one cycle later.

Top module: `xsh_unit`

## Requirements
- R1: Option code bit 2 selects signed extension when 1 and unsigned when 0; bits 1:0 give the slice length: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits.
- R2: With an unsigned code, the result equals the source slice zero-extended and shifted left by `in_shamt`, with bits beyond the result width dropped.
- R3: With a signed code, the fill bit is the source bit at (effective length - 1). It is placed at result bit (effective length + shift - 1) and copied into every higher bit up to the result width.
- R4: The low `in_shamt` bits of a legal result are always zero.
- R5: With `in_narrow` = 1, the result width is 32, only source bits 31:0 are used, and result bits 63:32 are zero; word and doubleword codes then give identical results.
- R6: The effective slice length is the smaller of the coded length and (result width - shift), so a shifted doubleword or narrow-mode word loses its top source bits.
- R7: `out_valid` is high in the cycle after a clock edge where `in_valid` was high, and low after an edge where it was low; the result and error flag belong to that sampled input.
- R8: A shift amount above 4 sets `out_shift_err` and forces `out_result` to zero; a legal shift clears `out_shift_err`.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_result` and `out_shift_err`.
- R10: While `in_valid` is low, `out_result` and `out_shift_err` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample the operand inputs on this edge |
| in_operand | input | 64 | Source register value |
| in_opt | input | 3 | Extend-option code (sign select, slice size) |
| in_shamt | input | 3 | Left-shift amount, legal range 0 to 4 |
| in_narrow | input | 1 | 1 = 32-bit result, 0 = 64-bit result |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 64 | Extended and shifted operand |
| out_shift_err | output | 1 | Last sampled shift amount was above 4 |

## Verification
Every output is due exactly one rising edge after the edge that samples `in_valid`. The bench drives inputs on the falling edge, lets one rising edge pass, and compares on the following falling edge, so each comparison falls half a cycle after the register updates. The hold and reset checks use the same timing: an idle cycle or a reset cycle is applied, and the outputs are read on the next falling edge. The expected values come from a separate arithmetic model that extends first and shifts second, not from the fused per-bit form.

// File: rtl/xsh_pkg.sv
package xsh_pkg;

  // Slice size selected by the two low option bits
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } slice_e;

  typedef struct packed {
    logic   is_signed;
    slice_e size;
  } ext_ctrl_t;

endpackage

// File: rtl/xsh_decode.sv
module xsh_decode
  import xsh_pkg::*;
(
  input  logic [2:0] opt,
  output ext_ctrl_t  ctrl
);

  always_comb begin
    ctrl.is_signed = opt[2];
    unique case (opt[1:0])
      2'b00:   ctrl.size = SZ_BYTE;
      2'b01:   ctrl.size = SZ_HALF;
      2'b10:   ctrl.size = SZ_WORD;
      default: ctrl.size = SZ_DBL;
    endcase
  end

endmodule

// File: rtl/xsh_len.sv
module xsh_len
  import xsh_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int SH_W     = 3,
  localparam int LEN_W   = $clog2(DATA_W) + 1
) (
  input  slice_e             size,
  input  logic               narrow,
  input  logic [SH_W-1:0]    shamt,
  output logic [LEN_W-1:0]   eff_len,
  output logic [LEN_W-1:0]   res_w
);

  logic [LEN_W-1:0] coded_len;
  logic [LEN_W-1:0] room;

  always_comb begin
    unique case (size)
      SZ_BYTE: coded_len = LEN_W'(8);
      SZ_HALF: coded_len = LEN_W'(16);
      SZ_WORD: coded_len = LEN_W'(32);
      default: coded_len = LEN_W'(DATA_W);
    endcase
    res_w   = narrow ? LEN_W'(NARROW_W) : LEN_W'(DATA_W);
    room    = res_w - LEN_W'(shamt);
    eff_len = (coded_len < room) ? coded_len : room;
  end

endmodule

// File: rtl/xsh_core.sv
module xsh_core #(
  parameter int DATA_W = 64,
  parameter int SH_W   = 3,
  localparam int LEN_W = $clog2(DATA_W) + 1,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              is_signed,
  input  logic [SH_W-1:0]   shamt,
  input  logic [LEN_W-1:0]  eff_len,
  input  logic [LEN_W-1:0]  res_w,
  output logic [DATA_W-1:0] result
);

  logic [LEN_W-1:0] top_idx;
  logic             fill;

  // Fused extend and shift: each result bit picks zero, a source bit, or the fill bit
  always_comb begin
    top_idx = eff_len - LEN_W'(1);
    fill    = is_signed & operand[top_idx[IDX_W-1:0]];
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(shamt))
        result[i] = 1'b0;
      else if (i < int'(eff_len) + int'(shamt))
        result[i] = operand[i - int'(shamt)];
      else if (i < int'(res_w))
        result[i] = fill;
      else
        result[i] = 1'b0;
    end
  end

endmodule

// File: rtl/xsh_unit.sv
module xsh_unit
  import xsh_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NARROW_W  = 32,
  parameter int SH_W      = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [2:0]        in_opt,
  input  logic [SH_W-1:0]   in_shamt,
  input  logic              in_narrow,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_shift_err
);

  localparam int LEN_W = $clog2(DATA_W) + 1;

  ext_ctrl_t        ctrl;
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] res_w;
  logic [DATA_W-1:0] shaped;
  logic              bad_shift;

  xsh_decode u_decode (
    .opt  (in_opt),
    .ctrl (ctrl)
  );

  xsh_len #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .SH_W     (SH_W)
  ) u_len (
    .size    (ctrl.size),
    .narrow  (in_narrow),
    .shamt   (in_shamt),
    .eff_len (eff_len),
    .res_w   (res_w)
  );

  xsh_core #(
    .DATA_W (DATA_W),
    .SH_W   (SH_W)
  ) u_core (
    .operand   (in_operand),
    .is_signed (ctrl.is_signed),
    .shamt     (in_shamt),
    .eff_len   (eff_len),
    .res_w     (res_w),
    .result    (shaped)
  );

  assign bad_shift = int'(in_shamt) > MAX_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_shift_err <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result    <= bad_shift ? '0 : shaped;
        out_shift_err <= bad_shift;
      end
    end
  end

endmodule

// File: rtl/xsh_unit_checker.sv
module xsh_unit_checker #(
  parameter int DATA_W    = 64,
  parameter int NARROW_W  = 32,
  parameter int SH_W      = 3,
  parameter int MAX_SHIFT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SH_W-1:0]   in_shamt,
  input logic              in_narrow,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_shift_err
);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r8_err_raised: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int'(in_shamt) > MAX_SHIFT) |=> (out_shift_err && out_result == '0));

  a_r8_err_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int'(in_shamt) <= MAX_SHIFT) |=> !out_shift_err);

  a_r4_low_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int'(in_shamt) <= MAX_SHIFT) |=>
      ((out_result & ((DATA_W'(1) << $past(in_shamt)) - DATA_W'(1))) == '0));

  a_r5_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_narrow) |=> (out_result[DATA_W-1:NARROW_W] == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(out_result) && $stable(out_shift_err)));

  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && !out_shift_err));

endmodule

bind xsh_unit xsh_unit_checker #(
  .DATA_W    (DATA_W),
  .NARROW_W  (NARROW_W),
  .SH_W      (SH_W),
  .MAX_SHIFT (MAX_SHIFT)
) u_xsh_unit_checker (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_shamt      (in_shamt),
  .in_narrow     (in_narrow),
  .out_valid     (out_valid),
  .out_result    (out_result),
  .out_shift_err (out_shift_err)
);

// File: tb/xsh_unit_bench.sv
module xsh_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_operand;
  logic [2:0]  in_opt;
  logic [2:0]  in_shamt;
  logic        in_narrow;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_shift_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xsh_unit u_xsh_unit (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_operand    (in_operand),
    .in_opt        (in_opt),
    .in_shamt      (in_shamt),
    .in_narrow     (in_narrow),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_shift_err (out_shift_err)
  );

  // Extend first, then shift, then trim to the result width
  function automatic logic [63:0] model(input logic [63:0] op, input logic [2:0] opt,
                                        input int sh, input bit nar);
    int          rw;
    int          ln;
    logic [63:0] m;
    logic [63:0] v;
    rw = nar ? 32 : 64;
    ln = 8 << opt[1:0];
    if (ln > rw) ln = rw;
    v = op;
    if (ln < 64) begin
      m = (64'd1 << ln) - 64'd1;
      v = v & m;
      if (opt[2] && v[ln-1]) v = v | ~m;
    end
    v = v << sh;
    if (rw < 64) v = v & ((64'd1 << rw) - 64'd1);
    if (sh > 4) v = '0;
    return v;
  endfunction

  function automatic logic [63:0] pick(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8080_8080_8080_8080;
      3: return 64'h0000_8000_8000_8080;
      4: return 64'h7F7F_7FFF_7FFF_FF7F;
      5: return 64'h8000_0000_8000_0000;
      6: return 64'h0123_4567_89AB_CDEF;
      7: return 64'h4000_0000_4000_4040;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic [2:0] opt, input int sh, input bit nar);
    @(negedge clk);
    in_valid   = 1'b1;
    in_operand = op;
    in_opt     = opt;
    in_shamt   = 3'(sh);
    in_narrow  = nar;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] exp;
    logic [63:0] held;
    string       tag;
    rst = 1'b1; in_valid = 1'b0; in_operand = '1; in_opt = '0; in_shamt = '0; in_narrow = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 valid", 64'(out_valid), 64'd0);
    check("R9 result", out_result, 64'd0);
    check("R9 err", 64'(out_shift_err), 64'd0);
    rst = 1'b0;

    // R1 directed decodes
    apply(64'hFFFF_FFFF_FFFF_FF80, 3'b000, 0, 1'b0);
    check("R1 ubyte", out_result, 64'h80);
    apply(64'h0000_0000_0000_8000, 3'b101, 0, 1'b0);
    check("R1 shalf", out_result, 64'hFFFF_FFFF_FFFF_8000);
    apply(64'h0000_0001_8000_0000, 3'b110, 1, 1'b0);
    check("R1 sword", out_result, 64'hFFFF_FFFF_0000_0000);
    // R6 clamp: shifted doubleword drops top bits
    apply(64'hF000_0000_0000_0001, 3'b011, 4, 1'b0);
    check("R6 dbl", out_result, 64'h0000_0000_0000_0010);

    // Sweep
    for (int nar = 0; nar < 2; nar++)
      for (int opt = 0; opt < 8; opt++)
        for (int sh = 0; sh < 8; sh++)
          for (int k = 0; k < 12; k++) begin
            logic [63:0] op;
            op  = pick(k);
            exp = model(op, 3'(opt), sh, nar[0]);
            apply(op, 3'(opt), sh, nar[0]);
            if (sh > 4)                tag = "R8 result";
            else if (nar != 0)         tag = "R5 result";
            else if (opt[1:0] == 2'b11 && sh > 0) tag = "R6 result";
            else if (opt[2])           tag = "R3 result";
            else                       tag = "R2 result";
            check(tag, out_result, exp);
            check("R8 flag", 64'(out_shift_err), (sh > 4) ? 64'd1 : 64'd0);
            check("R7 valid", 64'(out_valid), 64'd1);
            if (sh <= 4)
              check("R4 low", out_result & ((64'd1 << sh) - 64'd1), 64'd0);
          end

    // R5: word and doubleword agree in narrow mode
    apply(64'hABCD_0000_9234_5678, 3'b110, 2, 1'b1);
    held = out_result;
    apply(64'hABCD_0000_9234_5678, 3'b111, 2, 1'b1);
    check("R5 word=dbl", out_result, held);

    // R7/R10: idle cycle drops valid and holds data
    apply(64'h1234, 3'b001, 3, 1'b0);
    held = out_result;
    @(negedge clk);
    check("R7 idle", 64'(out_valid), 64'd0);
    check("R10 hold", out_result, held);
    in_operand = '1; in_opt = 3'b111; in_shamt = 3'd7;
    @(negedge clk);
    check("R10 hold2", out_result, held);
    check("R10 err", 64'(out_shift_err), 64'd0);

    // R9: reset after activity
    apply(64'hFF, 3'b100, 7, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 err clr", 64'(out_shift_err), 64'd0);
    check("R9 valid clr", 64'(out_valid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule